// File: doc/BRIEF.md
# Multicycle Multiply Issue Controller

This block wraps a signed multiplier whose combinational logic sits between an input register pair and an output register, and treats that logic as a multicycle path. An operand pair is loaded into the input registers only when the block accepts it. The product is loaded into the output register exactly `LAT` cycles later, and the result is always read from that register. The multiply itself is modeled behaviourally as a wave of in-flight values travelling through the logic cloud. Physical delay balancing lies outside this model.

A single copy of the datapath may take a new operand only once every `II` cycles. To keep the issue rate at one operand per cycle, the block builds `COPIES` identical lanes and hands accepted operands to them in a fixed rotation. Each lane has the same latency, so results come out in the order their operands went in, with at most one result per cycle. The upstream side uses a valid/ready handshake. The downstream side receives a one-cycle result-valid pulse together with the product.

Top module: `mc_mul_issue`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: An operand pair accepted at clock edge k (`in_valid` and `in_ready` both high) produces `out_valid` high for exactly one cycle, following edge k+`LAT`. `LAT` defaults to 5.
- R3: `out_prod` in a valid cycle equals the full signed product of the two's-complement operands `in_a` and `in_b`. The product is `P_W` bits wide (default 128) and the operands are `A_W` bits wide (default 64).
- R4: Accepted operands go to the lanes in strict rotation, starting at lane 0 after reset. With a legal configuration (`COPIES` >= `II`), `in_ready` stays high on every cycle, so back-to-back operands are all accepted.
- R5: Results appear in acceptance order, with at most one `out_valid` pulse per cycle.
- R6: Reset discards all in-flight operands and returns the rotation to lane 0. No `out_valid` appears after reset until a new operand is accepted.
- R7: Changes on `in_a` and `in_b` while `in_valid` is low do not affect any result in flight.
- R8: Between result-valid pulses, `out_prod` keeps the value of the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Lane next in rotation can take an operand |
| in_a | input | A_W | Signed operand A |
| in_b | input | A_W | Signed operand B |
| out_valid | output | 1 | One-cycle result pulse |
| out_prod | output | P_W | Signed product, held between pulses |

## Verification
The hardest situation to reach is one where a lane holds several operands in flight at once. In that situation the lane's input registers have already been overwritten while an older wave is still travelling, and the two results must not mix. Back-to-back streams of extreme-value operands from the vector table create it, because with `II` below `LAT` every lane carries overlapping waves. Idle cycles that wiggle the operand pins, and a reset in the middle of a burst, cover the ignored-input and flush cases.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mcm_issue_rr.sv
module mcm_issue_rr #(
  parameter int unsigned COPIES = 2,
  localparam int unsigned PTR_W = mcm_pkg::idx_w(COPIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COPIES-1:0] lane_ready,
  output logic              in_ready,
  output logic [COPIES-1:0] load
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             accept;

  always_comb begin
    in_ready = lane_ready[ptr_q];
    accept   = in_valid & in_ready;
    load     = '0;
    load[ptr_q] = accept;
    ptr_d = ptr_q;
    if (accept) begin
      if (ptr_q == PTR_W'(COPIES - 1)) ptr_d = '0;
      else                             ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load)); // R4
  AST_LOAD_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (load != '0) |-> in_valid); // R4
endmodule

// File: rtl/mcm_lane.sv
module mcm_lane #(
  parameter int unsigned A_W = 64,
  parameter int unsigned P_W = 128,
  parameter int unsigned LAT = 5,
  parameter int unsigned II  = 2,
  localparam int unsigned CNT_W = $clog2(II + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic [A_W-1:0] a_i,
  input  logic [A_W-1:0] b_i,
  output logic           ready_o,
  output logic           cap_o,
  output logic [P_W-1:0] prod_o
);
  logic [A_W-1:0]   a_q, b_q;
  logic [P_W-1:0]   ext_a, ext_b, prod_c;
  logic [LAT-1:0]   tag_q, tag_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic [P_W-1:0]   wave_q [1:LAT-1];
  logic [P_W-1:0]   out_q;
  logic             vld_q;

  // behavioural combinational cloud between input and output registers
  always_comb begin
    ext_a  = {{(P_W-A_W){a_q[A_W-1]}}, a_q};
    ext_b  = {{(P_W-A_W){b_q[A_W-1]}}, b_q};
    prod_c = ext_a * ext_b;
  end

  always_comb begin
    tag_d = {tag_q[LAT-2:0], load_i};
    gap_d = gap_q;
    if (load_i)              gap_d = CNT_W'(II - 1);
    else if (gap_q != '0)    gap_d = gap_q - 1'b1;
    ready_o = (gap_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      gap_q <= '0;
      vld_q <= 1'b0;
    end else begin
      tag_q <= tag_d;
      gap_q <= gap_d;
      vld_q <= tag_q[LAT-1];
    end
  end

  // input registers: write enable is the accept strobe
  always_ff @(posedge clk) begin
    if (load_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  // in-flight wave positions inside the cloud
  generate
    for (genvar j = 1; j < LAT; j++) begin : g_wave
      if (j == 1) begin : g_head
        always_ff @(posedge clk) begin
          if (tag_q[0]) wave_q[1] <= prod_c;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (tag_q[j-1]) wave_q[j] <= wave_q[j-1];
        end
      end
    end
  endgenerate

  // output register: write enable fires LAT cycles after the input load
  always_ff @(posedge clk) begin
    if (tag_q[LAT-1]) out_q <= wave_q[LAT-1];
  end

  assign cap_o  = vld_q;
  assign prod_o = out_q;

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> ready_o); // R4
  AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && $past(rst_n)) |=> ($stable(a_q) && $stable(b_q))); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_o && !tag_q[LAT-1] && $past(rst_n)) |=> $stable(prod_o)); // R8
endmodule

// File: rtl/mcm_merge.sv
module mcm_merge #(
  parameter int unsigned COPIES = 2,
  parameter int unsigned P_W    = 128,
  localparam int unsigned SEL_W = mcm_pkg::idx_w(COPIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [COPIES-1:0]          cap_i,
  input  logic [COPIES-1:0][P_W-1:0] prod_i,
  output logic                       out_valid,
  output logic [P_W-1:0]             out_prod
);
  logic [SEL_W-1:0] last_q, sel_c;

  always_comb begin
    sel_c = last_q;
    for (int i = 0; i < COPIES; i++) begin
      if (cap_i[i]) sel_c = SEL_W'(i);
    end
    out_valid = |cap_i;
    out_prod  = prod_i[sel_c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_q <= '0;
    else if (out_valid) last_q <= sel_c;
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_i)); // R5
endmodule

// File: rtl/mc_mul_issue.sv
module mc_mul_issue #(
  parameter int unsigned A_W    = 64,
  parameter int unsigned P_W    = 128,
  parameter int unsigned LAT    = 5,
  parameter int unsigned II     = 2,
  parameter int unsigned COPIES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [A_W-1:0] in_a,
  input  logic [A_W-1:0] in_b,
  output logic           out_valid,
  output logic [P_W-1:0] out_prod
);
  logic [COPIES-1:0]          lane_ready, load, cap;
  logic [COPIES-1:0][P_W-1:0] prod;

  generate
    if (COPIES < II) begin : g_bad_rate
      $error("COPIES must be at least II for one operand per cycle");
    end
    if (LAT < 2) begin : g_bad_lat
      $error("LAT must be at least 2");
    end
    if (P_W < 2 * A_W) begin : g_bad_width
      $error("P_W must hold the full product");
    end
  endgenerate

  mcm_issue_rr #(.COPIES(COPIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lane_ready(lane_ready), .in_ready(in_ready), .load(load)
  );

  generate
    for (genvar c = 0; c < COPIES; c++) begin : g_lane
      mcm_lane #(.A_W(A_W), .P_W(P_W), .LAT(LAT), .II(II)) u_lane (
        .clk(clk), .rst_n(rst_n), .load_i(load[c]),
        .a_i(in_a), .b_i(in_b), .ready_o(lane_ready[c]),
        .cap_o(cap[c]), .prod_o(prod[c])
      );
    end
  endgenerate

  mcm_merge #(.COPIES(COPIES), .P_W(P_W)) u_merge (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .prod_i(prod),
    .out_valid(out_valid), .out_prod(out_prod)
  );

  AST_READY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && $past(rst_n)) |=> in_ready); // R4
endmodule

// File: tb/mc_mul_issue_tb.sv
module mc_mul_issue_tb;
  localparam int A_W = 64, P_W = 128, LAT = 5, II = 2, COPIES = 2;
  localparam int NV = 10;
  localparam logic [63:0] VA [NV] = '{64'd0, 64'd1, -64'sd1, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd123456789,
    64'h0000_0001_0000_0000, -64'sd7, 64'hDEAD_BEEF_0123_4567};
  localparam logic [63:0] VB [NV] = '{64'd55, 64'd1, -64'sd1, 64'h7FFF_FFFF_FFFF_FFFF,
    64'h8000_0000_0000_0000, -64'sd1, -64'sd987654321,
    64'h0000_0001_0000_0000, 64'd3, 64'h0BAD_F00D_7654_3210};

  logic clk = 0, rst_n, in_valid, in_ready, out_valid;
  logic [A_W-1:0] in_a, in_b;
  logic [P_W-1:0] out_prod;
  int errors = 0, checks = 0, cyc = 0;
  logic         sched_v [512];
  logic [P_W-1:0] sched_p [512];
  logic [P_W-1:0] last_exp;
  logic have_last = 0, mon_en = 0, done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mc_mul_issue #(.A_W(A_W), .P_W(P_W), .LAT(LAT), .II(II), .COPIES(COPIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod));

  function automatic logic [P_W-1:0] mul_ref(input logic [63:0] a, input logic [63:0] b);
    logic signed [P_W-1:0] ea, eb;
    ea = {{(P_W-A_W){a[A_W-1]}}, a};
    eb = {{(P_W-A_W){b[A_W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  // monitor at falling edge: R2 timing, R3 value, R5 order, R8 hold
  always @(negedge clk) begin
    if (mon_en) begin
      int k;
      k = cyc % 512;
      if (sched_v[k] || out_valid) begin
        chk(out_valid == sched_v[k], "R2/R5 valid timing", {127'd0, out_valid}, {127'd0, sched_v[k]});
        if (sched_v[k] && out_valid) begin
          chk(out_prod == sched_p[k], "R3/R5 product", out_prod, sched_p[k]);
          last_exp  = sched_p[k];
          have_last = 1;
        end
      end else if (have_last) begin
        chk(out_prod == last_exp, "R8 hold", out_prod, last_exp);
      end
      sched_v[k] = 0;
    end
  end

  task automatic offer(input logic [63:0] a, input logic [63:0] b);
    int k;
    in_valid = 1; in_a = a; in_b = b;
    #1;
    chk(in_ready == 1'b1, "R4 ready", {127'd0, in_ready}, 128'd1);
    if (in_ready) begin
      k = (cyc + 1 + LAT) % 512;
      sched_v[k] = 1;
      sched_p[k] = mul_ref(a, b);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(input int n, input bit wiggle);
    for (int i = 0; i < n; i++) begin
      if (wiggle) begin in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom}; end
      @(negedge clk);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) sched_v[i] = 0;
    rst_n = 0; in_valid = 0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 valid in reset", {127'd0, out_valid}, 128'd0);
    chk(in_ready == 1, "R1 ready in reset", {127'd0, in_ready}, 128'd1);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 valid after reset", {127'd0, out_valid}, 128'd0);
    mon_en = 1;

    // table walk, back-to-back: overlapping waves in every lane (R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) offer(VA[v], VB[v]);
    idle(LAT + 3, 0);

    // sparse issue with pins wiggling while idle (R7)
    offer(-64'sd123456, 64'd99999);
    idle(2, 1);
    offer(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
    idle(LAT + 3, 1);

    // reset during a burst: flush in flight (R6)
    for (int v = 0; v < 4; v++) offer(VA[v+3], VB[v+3]);
    rst_n = 0;
    for (int i = 0; i < 512; i++) sched_v[i] = 0;
    have_last = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < LAT + 4; i++) begin
      chk(out_valid == 0, "R6 no result after reset", {127'd0, out_valid}, 128'd0);
      @(negedge clk);
    end

    // rotation restarts at lane 0 and works again (R4 R6)
    for (int v = 0; v < 5; v++) offer(VA[NV-1-v], VB[v]);
    idle(LAT + 3, 1);

    done = 1;
    report();
  end
endmodule